// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

A nine-pin general-purpose I/O port driven from a small memory-mapped register bus. Three registers each give every pin one bit. The ownership register hands a pin either to the port's own GPIO logic or to an on-chip serial peripheral. The direction register chooses input or output. The data register holds the value to drive. The block turns those registers, the live pin levels and the peripheral's per-pin drive signals into per-pin output values, tri-state enables and synchronized input taps for the peripheral.

The port advances on the processor's instruction-cycle strobe `cyc_en_i`. Bus writes are taken only on strobed edges. A value written to the data register reaches the pins on the next strobed edge, so the pin update lags the write by exactly one instruction cycle. Stalled cycles stretch that lag by the same amount. Reading the data register returns the latched value on pins whose direction bit is 1 and the synchronized pin level on pins whose direction bit is 0. This rule also holds on pins that the peripheral owns, so software can watch a peripheral's pins while it runs.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is asserted, the ownership and direction registers read back as zero and every `pin_oe_o` bit is 0. All pins therefore start as GPIO inputs.
- R2: On a GPIO pin (ownership bit 0), `pin_oe_o` equals that pin's direction bit (1 = output) and `pin_o` carries the pin's output-stage value.
- R3: On a peripheral pin (ownership bit 1), `pin_o` and `pin_oe_o` follow `per_out_i` and `per_oe_i`, and the direction bit has no effect on them.
- R4: For a pin whose direction bit is 0, a read of the data register returns the pin level delayed by a two-flop synchronizer, which adds two clock edges. A data write to such a pin updates the latch and leaves `pin_oe_o` at 0.
- R5: For a GPIO pin whose direction bit is 1, a read of the data register returns the latched value, whatever the pin level is.
- R6: The readback rule of R4 and R5 depends only on the direction bit, and it also applies to pins that the peripheral owns.
- R7: A data write taken on a strobed edge does not change `pin_o` at that edge. It appears on `pin_o` at the next edge where `cyc_en_i` is 1.
- R8: While `cyc_en_i` is 0, the output stage holds its value and bus writes are ignored.
- R9: The register addresses are: `addr_i` 0 for ownership, 1 for direction, 2 for data. Address 3 reads zero. Register bits 23..9 read zero, and write data in those bits is dropped.
- R10: `per_in_o` gives the synchronized pin level on peripheral-owned pins and 0 on GPIO pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle strobe; 0 stalls the port |
| wr_i | input | 1 | Register write request |
| addr_i | input | 2 | Register select |
| wdata_i | input | 24 | Write data |
| rdata_o | output | 24 | Read data for the register selected by `addr_i` |
| pin_i | input | 9 | Pin input levels from the pads |
| pin_o | output | 9 | Pin output values to the pads |
| pin_oe_o | output | 9 | Pin output enables (1 = drive) |
| per_out_i | input | 9 | Peripheral output values per pin |
| per_oe_i | input | 9 | Peripheral output enables per pin |
| per_in_o | output | 9 | Synchronized pin levels tapped for the peripheral |

## Verification
The lag and stall assertions assume that `cyc_en_i` is a clean synchronous strobe, so that a write and the pin update are both seen on strobed edges only. The synchronizer latency check assumes that `pin_i` is sampled only on clock edges. The stimulus therefore changes every input one time unit after a rising edge and holds it until the next edge. It also checks readback only after at least two edges have passed since the last pin change, except where the two-edge latency itself is the point of the check. Peripheral drive inputs are held steady while the direction register is rewritten, so that any change on an owned pin can only come from the direction bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  typedef enum logic [REG_ADDR_W-1:0] {
    REG_OWN  = 2'd0,
    REG_DIR  = 2'd1,
    REG_DAT  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned N_PINS = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] sync_o
);
  logic [N_PINS-1:0] s1_q, s2_q;
  logic [1:0]        age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;

  // checker-only age counter, saturates once both stages hold live data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  a_r4_sync_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (sync_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS = 9,
  parameter int unsigned DATA_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cyc_en_i,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [N_PINS-1:0]     pin_sync_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [N_PINS-1:0]     own_o,
  output logic [N_PINS-1:0]     dir_o,
  output logic [N_PINS-1:0]     out_o
);
  logic [N_PINS-1:0] own_q, dir_q, dat_q, out_q;
  logic [N_PINS-1:0] wfield, rd_dat;
  logic              wr_ok;
  reg_sel_e          sel;
  logic              unused_hi;

  assign sel       = reg_sel_e'(addr_i);
  assign wr_ok     = wr_i & cyc_en_i;
  assign wfield    = wdata_i[N_PINS-1:0];
  assign unused_hi = ^wdata_i[DATA_W-1:N_PINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
      dir_q <= '0;
      dat_q <= '0;
    end else if (wr_ok) begin
      case (sel)
        REG_OWN: own_q <= wfield;
        REG_DIR: dir_q <= wfield;
        REG_DAT: dat_q <= wfield;
        default: ;
      endcase
    end
  end

  // output stage: one instruction cycle behind the data latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= '0;
    else if (cyc_en_i) out_q <= dat_q;
  end

  assign rd_dat = (dir_q & dat_q) | (~dir_q & pin_sync_i);

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_OWN: rdata_o = DATA_W'(own_q);
      REG_DIR: rdata_o = DATA_W'(dir_q);
      REG_DAT: rdata_o = DATA_W'(rd_dat);
      default: rdata_o = '0;
    endcase
  end

  assign own_o = own_q;
  assign dir_o = dir_q;
  assign out_o = out_q;

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (own_q == '0 && dir_q == '0));

  a_r7_one_cycle_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_en_i |=> (out_q == $past(dat_q)));

  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_i |=> ($stable(out_q) && $stable(dat_q) && $stable(own_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
  parameter int unsigned N_PINS = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] own_i,
  input  logic [N_PINS-1:0] dir_i,
  input  logic [N_PINS-1:0] gpio_out_i,
  input  logic [N_PINS-1:0] pin_sync_i,
  input  logic [N_PINS-1:0] per_out_i,
  input  logic [N_PINS-1:0] per_oe_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic [N_PINS-1:0] per_in_o
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign pin_o[i]    = own_i[i] ? per_out_i[i] : gpio_out_i[i];
    assign pin_oe_o[i] = own_i[i] ? per_oe_i[i]  : dir_i[i];
    assign per_in_o[i] = own_i[i] & pin_sync_i[i];
  end

  a_r2_gpio_input_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~own_i & ~dir_i & pin_oe_o) == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS = 9,
  parameter int unsigned DATA_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cyc_en_i,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [N_PINS-1:0]     pin_i,
  output logic [N_PINS-1:0]     pin_o,
  output logic [N_PINS-1:0]     pin_oe_o,
  input  logic [N_PINS-1:0]     per_out_i,
  input  logic [N_PINS-1:0]     per_oe_i,
  output logic [N_PINS-1:0]     per_in_o
);
  logic [N_PINS-1:0] pin_sync, own, dir, gpio_out;

  gpio_port_sync #(.N_PINS(N_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (pin_sync)
  );

  gpio_port_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_en_i   (cyc_en_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pin_sync_i (pin_sync),
    .rdata_o    (rdata_o),
    .own_o      (own),
    .dir_o      (dir),
    .out_o      (gpio_out)
  );

  gpio_port_pinmux #(.N_PINS(N_PINS)) u_pinmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .own_i      (own),
    .dir_i      (dir),
    .gpio_out_i (gpio_out),
    .pin_sync_i (pin_sync),
    .per_out_i  (per_out_i),
    .per_oe_i   (per_oe_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .per_in_o   (per_in_o)
  );
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  import gpio_port_pkg::*;

  localparam int unsigned N = 9;
  localparam int unsigned W = 24;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b1;
  logic          cyc_en = 1'b1;
  logic          wr = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic [N-1:0]  pin_i = 9'h0A5;
  logic [N-1:0]  pin_o, pin_oe, per_in;
  logic [N-1:0]  per_out = '0, per_oe = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef enum int {K_RDATA, K_PIN, K_OE, K_PERIN} kind_e;
  typedef struct {
    kind_e        kind;
    logic [W-1:0] exp;
    string        req;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk; // 125 MHz

  gpio_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_en_i(cyc_en), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe),
    .per_out_i(per_out), .per_oe_i(per_oe), .per_in_o(per_in)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_RDATA: act = rdata;
        K_PIN:   act = W'(pin_o);
        K_OE:    act = W'(pin_oe);
        default: act = W'(per_in);
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%06h expected=%06h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_val(kind_e k, logic [W-1:0] e, string req);
    item_t it;
    it.kind = k; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr_reg(reg_sel_e a, logic [W-1:0] d);
    addr = a; wdata = d; wr = 1'b1; cyc_en = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic rd_chk(reg_sel_e a, logic [W-1:0] e, string req);
    addr = a;
    expect_val(K_RDATA, e, req);
    step();
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    step();
    expect_val(K_OE, 0, "R1");
    rd_chk(REG_OWN, 0, "R1");
    rd_chk(REG_DIR, 0, "R1");
    rst_ni = 1'b1;
    repeat (3) step();

    // R4: input pin readback after synchronizer
    rd_chk(REG_DAT, 24'h0000A5, "R4");
    wr_reg(REG_DAT, 24'h00013C);
    expect_val(K_OE, 0, "R4");
    rd_chk(REG_DAT, 24'h0000A5, "R4");

    // R2 / R5: mixed directions on GPIO pins
    wr_reg(REG_DIR, 24'h0001F0);
    expect_val(K_OE, 24'h0001F0, "R2");
    expect_val(K_PIN, 24'h00013C, "R2");
    rd_chk(REG_DAT, 24'h000135, "R5");

    // R7: pin update one strobed edge after the write
    wr_reg(REG_DAT, 24'h0000C3);
    expect_val(K_PIN, 24'h00013C, "R7");
    step();
    expect_val(K_PIN, 24'h0000C3, "R7");
    step();

    // R8: stall holds output and drops writes
    wr_reg(REG_DAT, 24'h000055);
    cyc_en = 1'b0;
    step(); step();
    expect_val(K_PIN, 24'h0000C3, "R8");
    addr = REG_DAT; wdata = 24'h0001AA; wr = 1'b1;
    step();
    wr = 1'b0;
    cyc_en = 1'b1;
    expect_val(K_PIN, 24'h0000C3, "R8");
    step();
    expect_val(K_PIN, 24'h000055, "R8");
    rd_chk(REG_DAT, 24'h000055, "R8");

    // R3 / R6: peripheral owns pins 3..0
    pin_i = 9'h0AA; per_out = 9'h00A; per_oe = 9'h003;
    wr_reg(REG_DIR, 24'h0001FF);
    wr_reg(REG_OWN, 24'h00000F);
    expect_val(K_OE, 24'h0001F3, "R3");
    expect_val(K_PIN, 24'h00005A, "R3");
    rd_chk(REG_DAT, 24'h000055, "R6");
    wr_reg(REG_DIR, 24'h0001F0);
    expect_val(K_OE, 24'h0001F3, "R3");
    expect_val(K_PIN, 24'h00005A, "R3");
    rd_chk(REG_DAT, 24'h00005A, "R6");

    // R10: peripheral taps, two-edge latency
    expect_val(K_PERIN, 24'h00000A, "R10");
    step();
    pin_i = 9'h1F5;
    step();
    expect_val(K_PERIN, 24'h00000A, "R10");
    step();
    expect_val(K_PERIN, 24'h000005, "R10");
    step();

    // R9: address map and upper bits
    rd_chk(REG_NONE, 0, "R9");
    rd_chk(REG_OWN, 24'h00000F, "R9");
    wr_reg(REG_OWN, 24'hFFFFFF);
    expect_val(K_OE, 24'h000003, "R3");
    rd_chk(REG_OWN, 24'h0001FF, "R9");
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule